// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the write-capture latches of a byte-wide nonvolatile memory and its page write controller. Every captured write (a 13-bit address and an 8-bit data byte, marked by a one-cycle strobe) passes through it. For each one the block raises or lowers a commit enable in the same cycle, and the page controller stores the byte only when that enable is high.

The block matches two fixed command sequences written at two command addresses. A three-byte lock sequence turns protection on and opens a write window. The window lets the data bytes of one page through until the page controller starts its program cycle. A six-byte release sequence turns protection off. Command bytes are never stored. While protection is on and no window is open, ordinary bytes are dropped. The page controller's byte-load-window lapse is an input here, so a sequence whose bytes come too far apart is abandoned.

Top module: `wp_sequencer`

## Requirements
- R1: After a synchronous active-low reset, protection is off, the write window is closed and the matcher is at its start.
- R2: The lock sequence is address 0x1555 with data 0xAA, then 0x0AAA with 0x55, then 0x1555 with 0xA0. None of its bytes is committed. From the cycle after its last byte, protection is on and the write window is open.
- R3: With protection off, a byte that is not a matched command byte is committed in the same cycle as its write strobe.
- R4: With protection on and the write window closed, no byte is committed.
- R5: With the window open, data bytes are committed. The window closes in the cycle after a program-start pulse, and protection stays on.
- R6: The release sequence is 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20. None of its bytes is committed. From the cycle after its last byte, protection is off and the window is closed.
- R7: A byte that does not match the expected next step sends the matcher back to its start. That byte is handled as ordinary data: it is committed with protection off and dropped with protection on and the window closed.
- R8: A byte-load-window lapse pulse returns the matcher to its start. A write in the same cycle as the pulse is judged from the start.
- R9: A lock sequence received while protection is already on keeps protection on and opens the window.
- R10: The commit enable is low in every cycle without a write strobe.
- R11: The write window is never open while protection is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe for a captured write |
| wr_addr | input | 13 | Address of the captured write |
| wr_data | input | 8 | Data of the captured write |
| load_lapse | input | 1 | Pulse from the page controller: byte load window expired |
| prog_start | input | 1 | Pulse from the page controller: program cycle begins |
| commit_en | output | 1 | Store this byte (valid with wr_valid) |
| protect_on | output | 1 | Protection mode flag |
| window_open | output | 1 | One-page write window after a lock sequence |

## Verification
The assertions check on every cycle several properties that need no history: a commit appears only with a strobe, and only while protection is off or the window is open. The window never stands open without protection. The mode flag rises only after a 0xA0 byte at 0x1555 and falls only after a 0x20 byte there. The window closes only after a program start or a release byte. Only the bench scenarios can show that whole sequences are recognised in order. They also show that mismatches and lapses abandon a sequence part-way, that command bytes are withheld, and that the mode survives program cycles.

// File: rtl/wp_seq_pkg.sv
// Shared types and command codes for the write protection sequencer.
// Assumes byte-wide data; codes are zero-extended to the data width.
package wp_seq_pkg;

    // Matcher position: number of command bytes accepted so far
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_R3   = 3'd3,
        ST_R4   = 3'd4,
        ST_R5   = 3'd5
    } seq_st_t;

    // Outcome of judging one write against the matcher position
    typedef struct packed {
        logic cmd;      // byte belongs to a sequence, never stored
        logic lock;     // lock sequence completed
        logic release_; // release sequence completed
    } step_ev_t;

    localparam logic [7:0] CODE_KEY1 = 8'hAA;
    localparam logic [7:0] CODE_KEY2 = 8'h55;
    localparam logic [7:0] CODE_LOCK = 8'hA0;
    localparam logic [7:0] CODE_ARM  = 8'h80;
    localparam logic [7:0] CODE_FREE = 8'h20;

endpackage

// File: rtl/wp_step_match.sv
// Combinational step judge: compares one write against the byte the
// current matcher position expects and returns the next position and
// the events. Assumes the caller gates results with the write strobe.
module wp_step_match
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_P = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_Q = 13'h0AAA
) (
    input  seq_st_t             cur,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    output seq_st_t             nxt,
    output step_ev_t            ev
);

    localparam logic [DATA_W-1:0] K1 = DATA_W'(CODE_KEY1);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(CODE_KEY2);
    localparam logic [DATA_W-1:0] LK = DATA_W'(CODE_LOCK);
    localparam logic [DATA_W-1:0] AR = DATA_W'(CODE_ARM);
    localparam logic [DATA_W-1:0] FR = DATA_W'(CODE_FREE);

    logic at_p, at_q;

    // Decode which command address the write targets
    always_comb begin
        at_p = (addr == ADDR_P);
        at_q = (addr == ADDR_Q);
    end

    // Judge the byte against the expected step; a miss goes back to the start
    always_comb begin
        nxt = ST_IDLE;
        ev  = '0;
        case (cur)
            ST_IDLE: if (at_p && data == K1) begin nxt = ST_K1; ev.cmd = 1'b1; end
            ST_K1:   if (at_q && data == K2) begin nxt = ST_K2; ev.cmd = 1'b1; end
            ST_K2: begin
                if (at_p && data == LK) begin
                    ev.cmd  = 1'b1;
                    ev.lock = 1'b1;
                end else if (at_p && data == AR) begin
                    nxt    = ST_R3;
                    ev.cmd = 1'b1;
                end
            end
            ST_R3:   if (at_p && data == K1) begin nxt = ST_R4; ev.cmd = 1'b1; end
            ST_R4:   if (at_q && data == K2) begin nxt = ST_R5; ev.cmd = 1'b1; end
            ST_R5: begin
                if (at_p && data == FR) begin
                    ev.cmd      = 1'b1;
                    ev.release_ = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/wp_seq_track.sv
// Matcher position register. A lapse of the byte load window forces the
// position seen by the judge back to the start in the same cycle.
// Assumes load_lapse and wr_valid are single-cycle pulses.
module wp_seq_track
    import wp_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_valid,
    input  logic    load_lapse,
    input  seq_st_t nxt,
    output seq_st_t cur_eff
);

    seq_st_t pos_q;

    // Position the judge works from this cycle
    always_comb cur_eff = load_lapse ? ST_IDLE : pos_q;

    // Advance on each write, otherwise hold the (possibly cleared) position
    always_ff @(posedge clk) begin
        if (!rst_n)        pos_q <= ST_IDLE;
        else if (wr_valid) pos_q <= nxt;
        else               pos_q <= cur_eff;
    end

endmodule

// File: rtl/wp_mode_reg.sv
// Protection flag and write window. Lock sets both; release clears both;
// program start closes the window. Lock wins over a same-cycle program
// start so a window opened for the next page is not lost.
module wp_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_ev,
    input  logic release_ev,
    input  logic prog_start,
    output logic protect_q,
    output logic window_q
);

    // Protection flag: held across program cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          protect_q <= 1'b0;
        else if (release_ev) protect_q <= 1'b0;
        else if (lock_ev)    protect_q <= 1'b1;
    end

    // One-page write window following a lock
    always_ff @(posedge clk) begin
        if (!rst_n)          window_q <= 1'b0;
        else if (release_ev) window_q <= 1'b0;
        else if (lock_ev)    window_q <= 1'b1;
        else if (prog_start) window_q <= 1'b0;
    end

endmodule

// File: rtl/wp_sequencer.sv
// Top of the write protection sequencer. Judges each captured write,
// tracks the command sequence and the mode, and produces a same-cycle
// commit enable for the page write controller.
module wp_sequencer
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_P = 13'h1555,
    parameter logic [ADDR_W-1:0] ADDR_Q = 13'h0AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_lapse,
    input  logic              prog_start,
    output logic              commit_en,
    output logic              protect_on,
    output logic              window_open
);

    seq_st_t  cur_eff, nxt;
    step_ev_t ev;
    logic     lock_ev, release_ev;

    wp_seq_track u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .load_lapse (load_lapse),
        .nxt        (nxt),
        .cur_eff    (cur_eff)
    );

    wp_step_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ADDR_P (ADDR_P),
        .ADDR_Q (ADDR_Q)
    ) u_match (
        .cur  (cur_eff),
        .addr (wr_addr),
        .data (wr_data),
        .nxt  (nxt),
        .ev   (ev)
    );

    // Events only count on a real write
    always_comb begin
        lock_ev    = wr_valid & ev.lock;
        release_ev = wr_valid & ev.release_;
    end

    wp_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_ev    (lock_ev),
        .release_ev (release_ev),
        .prog_start (prog_start),
        .protect_q  (protect_on),
        .window_q   (window_open)
    );

    // Store only non-command bytes, and only when the mode allows it
    always_comb commit_en = wr_valid & ~ev.cmd & (~protect_on | window_open);

endmodule

// Checker for the sequencer's cycle-level rules.
module wp_sequencer_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_P = 13'h1555
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              prog_start,
    input logic              commit_en,
    input logic              protect_on,
    input logic              window_open
);

    // R10
    commit_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> wr_valid);

    // R4
    commit_needs_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (!protect_on || window_open));

    // R11
    window_needs_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> protect_on);

    // R2
    protect_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(protect_on) |-> $past(wr_valid && wr_addr == ADDR_P
                                    && wr_data == DATA_W'(8'hA0)));

    // R6
    protect_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect_on) |-> $past(wr_valid && wr_addr == ADDR_P
                                    && wr_data == DATA_W'(8'h20)));

    // R5
    window_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(window_open) |-> $past(prog_start || (wr_valid && wr_data == DATA_W'(8'h20))));

endmodule

bind wp_sequencer wp_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ADDR_P (ADDR_P)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .prog_start  (prog_start),
    .commit_en   (commit_en),
    .protect_on  (protect_on),
    .window_open (window_open)
);

// File: tb/wp_sequencer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module wp_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_lapse = 1'b0;
    logic        prog_start = 1'b0;
    logic        commit_en, protect_on, window_open;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wp_sequencer u_wp_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load_lapse  (load_lapse),
        .prog_start  (prog_start),
        .commit_en   (commit_en),
        .protect_on  (protect_on),
        .window_open (window_open)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write; commit is sampled mid-cycle, strobe dropped after the edge
    task automatic put(input logic [12:0] a, input logic [7:0] d,
                       input logic lapse, input logic exp_c, input string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; load_lapse = lapse;
        #2 check(commit_en == exp_c, req, commit_en, exp_c);
        @(posedge clk); #1;
        wr_valid = 1'b0; load_lapse = 1'b0;
    endtask

    task automatic pulse_prog();
        @(negedge clk); prog_start = 1'b1;
        @(posedge clk); #1 prog_start = 1'b0;
    endtask

    task automatic pulse_lapse();
        @(negedge clk); load_lapse = 1'b1;
        @(posedge clk); #1 load_lapse = 1'b0;
    endtask

    task automatic mode_is(input logic p, input logic w, input string req);
        check(protect_on == p, req, protect_on, p);
        check(window_open == w, req, window_open, w);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2 mode_is(1'b0, 1'b0, "R1");
        check(commit_en == 1'b0, "R10", commit_en, 0);
    endtask

    task automatic t_unprot_write();
        put(13'h0100, 8'h5A, 1'b0, 1'b1, "R3");
        put(13'h1555, 8'hA0, 1'b0, 1'b1, "R7 idle miss");
        mode_is(1'b0, 1'b0, "R3");
    endtask

    task automatic t_mismatch_open();
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R2 key1");
        put(13'h0AAA, 8'h33, 1'b0, 1'b1, "R7 abort");
        put(13'h1555, 8'hA0, 1'b0, 1'b1, "R7 restart");
        mode_is(1'b0, 1'b0, "R7");
    endtask

    task automatic t_lapse();
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R8 key1");
        pulse_lapse();
        put(13'h0AAA, 8'h55, 1'b0, 1'b1, "R8 after lapse");
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R8 key1 again");
        put(13'h0AAA, 8'h55, 1'b1, 1'b1, "R8 same-cycle lapse");
        mode_is(1'b0, 1'b0, "R8");
    endtask

    task automatic do_lock(input string req);
        put(13'h1555, 8'hAA, 1'b0, 1'b0, req);
        put(13'h0AAA, 8'h55, 1'b0, 1'b0, req);
        put(13'h1555, 8'hA0, 1'b0, 1'b0, req);
    endtask

    task automatic t_lock_window();
        do_lock("R2");
        mode_is(1'b1, 1'b1, "R2");
        put(13'h0040, 8'h11, 1'b0, 1'b1, "R5 window data");
        put(13'h0041, 8'h12, 1'b0, 1'b1, "R5 window data");
        pulse_prog();
        mode_is(1'b1, 1'b0, "R5");
        check(!window_open || protect_on, "R11", window_open, 0);
    endtask

    task automatic t_protected_drop();
        put(13'h0041, 8'h22, 1'b0, 1'b0, "R4");
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R7 key1");
        put(13'h0AAA, 8'h77, 1'b0, 1'b0, "R7 abort dropped");
        repeat (3) @(posedge clk);
        mode_is(1'b1, 1'b0, "R4 mode held");
    endtask

    task automatic t_relock();
        do_lock("R9");
        mode_is(1'b1, 1'b1, "R9");
        put(13'h0200, 8'h3C, 1'b0, 1'b1, "R9 window data");
        pulse_prog();
        mode_is(1'b1, 1'b0, "R9");
    endtask

    task automatic t_release();
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R6");
        put(13'h0AAA, 8'h55, 1'b0, 1'b0, "R6");
        put(13'h1555, 8'h80, 1'b0, 1'b0, "R6");
        put(13'h1555, 8'hAA, 1'b0, 1'b0, "R6");
        put(13'h0AAA, 8'h55, 1'b0, 1'b0, "R6");
        check(protect_on == 1'b1, "R6 before last", protect_on, 1);
        put(13'h1555, 8'h20, 1'b0, 1'b0, "R6");
        mode_is(1'b0, 1'b0, "R6");
        put(13'h0300, 8'h99, 1'b0, 1'b1, "R6 free write");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_unprot_write();
        t_mismatch_open();
        t_lapse();
        t_lock_window();
        t_protected_drop();
        t_relock();
        t_release();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule